// File: doc/BRIEF.md
# Low-Side Channel Fault Supervisor

This block sits between the serially loaded command bits of a four-channel low-side switch and the gate drivers of its output transistors. For every channel it decides whether the gate may be driven. It qualifies an overcurrent indication over a deglitch window, and after a trip it holds the channel off for a fixed retry interval before letting it run again. It also watches the open-load comparator while the channel is off and keeps one overcurrent latch and one open-load latch per channel. The two latches of each channel are merged into a single fault bit that the serial interface shifts out. A shared active-low fault line covers all latches plus the overtemperature flag.

The sensing itself (current limit, pull-down sources, comparators) lives outside and arrives as synchronous digital flags. Overtemperature switches every channel off until it clears. Undervoltage acts as a full reset of the block for as long as it is present. All intervals are counted in system clock cycles through parameters.

Each channel runs a four-state machine. CH_IDLE has the gate off. Idle→Drive happens when the command bit is set and no overtemperature is present. In CH_DRIVE the gate is on. Drive→Idle happens when the command bit is cleared or overtemperature rises. Drive→Qualify happens when overcurrent is seen. In CH_QUALIFY the gate is still on and the deglitch count runs. Qualify→Drive happens when overcurrent drops. Qualify→Idle happens on a cleared command or on overtemperature. Qualify→Retry happens when the count expires. In CH_RETRY the gate is off and the overcurrent latch is set. Retry→Idle happens when the retry count expires or the command bit is cleared. The open-load check is a separate per-channel counter and latch.

Top module: `lsd_fault_sup`

## Requirements
- R1: While `rst` is high, and at the first edge after it, every drive bit and every fault bit is 0 and `fault_n` is 1 (with `over_temp` low).
- R2: With no fault and no overtemperature, `ch_drive[i]` equals the value `ch_cmd[i]` had at the previous clock edge. A cleared command bit always turns its drive off at the next edge.
- R3: While channel i is driven, `ch_oc[i]` high at OCP_DG_CYC consecutive edges turns `ch_drive[i]` off and sets `ch_fault[i]` right after the last of those edges. A shorter run of samples has no effect, and the count restarts after any sample with `ch_oc[i]` low.
- R4: A tripped channel stays off with its fault bit set for RETRY_CYC cycles. The fault bit then clears on its own, and if the command bit is still set the drive comes back one edge later.
- R5: A tripped channel's overcurrent fault clears at the next edge when its command bit is cleared, or when `rst` is applied, without waiting for the retry interval.
- R6: While `ch_cmd[i]` is 0 and `ch_drive[i]` is off, `ch_open[i]` high at OL_DG_CYC consecutive edges sets the channel's open-load latch (seen as `ch_fault[i]`=1). A low sample restarts the count.
- R7: Setting `ch_cmd[i]` clears the channel's open-load latch at the next edge. `ch_open[i]` has no effect while the command bit is set.
- R8: `ch_fault[i]` is the OR of channel i's overcurrent and open-load latches. `fault_n` is 0 whenever any fault bit is 1 or `over_temp` is 1.
- R9: `over_temp` high at an edge turns every drive off after that edge. Drives follow their command bits again one edge after it clears.
- R10: `under_volt` high resets all latches, counters and drives at the next edge and keeps them cleared while it stays high. Normal operation resumes after it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_cmd | input | NCH | Commanded on state per channel (1 = on) |
| ch_oc | input | NCH | Overcurrent indication per channel |
| ch_open | input | NCH | Open-load comparator indication per channel |
| over_temp | input | 1 | Overtemperature flag |
| under_volt | input | 1 | Supply undervoltage flag |
| ch_drive | output | NCH | Gate enable per channel (1 = on) |
| ch_fault | output | NCH | Combined fault bit per channel for the serial interface |
| fault_n | output | 1 | Shared active-low fault indication |

## Verification
The overcurrent path is driven with a run one sample short of the deglitch window, then a broken run, then a full run. This separates an exact-count trip from an off-by-one or a counter that does not restart. The retry is observed on both sides of its last cycle, and it is also cut short by a cleared command and by reset, which distinguishes automatic recovery from the two forced clears. The open-load input is applied both with the command set and with it cleared, and with a glitch in the middle of its window. This shows that the latch is gated by the channel state and that it is cleared by the opposite command level from the overcurrent latch. Overtemperature and undervoltage are applied on top of active channels and latched faults, which shows the difference between a hold-off that resumes by itself and a full reset.

// File: rtl/lsd_fsup_pkg.sv
package lsd_fsup_pkg;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_DRIVE,
        CH_QUALIFY,
        CH_RETRY
    } ch_state_e;

    // bits needed to hold a count from 0 to n-1
    function automatic int cnt_bits(input int n);
        if (n <= 2) return 1;
        return $clog2(n);
    endfunction

endpackage

// File: rtl/lsd_ocp_fsm.sv
module lsd_ocp_fsm
    import lsd_fsup_pkg::*;
#(
    parameter int DG_CYC    = 438,
    parameter int RETRY_CYC = 150000
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd,
    input  logic oc,
    input  logic ot,
    output logic drive,
    output logic oc_latched
);

    localparam int CMAX = (DG_CYC > RETRY_CYC) ? DG_CYC : RETRY_CYC;
    localparam int CW   = cnt_bits(CMAX);
    localparam logic [CW-1:0] DG_LAST = CW'(DG_CYC - 1);
    localparam logic [CW-1:0] RT_LAST = CW'(RETRY_CYC - 1);

    ch_state_e       state_q, state_d;
    logic [CW-1:0]   cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= CH_IDLE;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (cmd && !ot) state_d = CH_DRIVE;
            end
            CH_DRIVE: begin
                if (!cmd || ot) state_d = CH_IDLE;
                else if (oc)    state_d = CH_QUALIFY;
            end
            CH_QUALIFY: begin
                if (!cmd || ot)           state_d = CH_IDLE;
                else if (!oc)             state_d = CH_DRIVE;
                else if (cnt_q == DG_LAST) state_d = CH_RETRY;
            end
            CH_RETRY: begin
                if (!cmd || cnt_q == RT_LAST) state_d = CH_IDLE;
            end
        endcase
    end

    // interval counter: restarts on every state change
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (state_q != state_d) begin
            cnt_q <= (state_d == CH_QUALIFY) ? CW'(1) : '0;
        end else if (state_q == CH_QUALIFY || state_q == CH_RETRY) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        drive      = 1'b0;
        oc_latched = 1'b0;
        unique case (state_q)
            CH_IDLE:    ;
            CH_DRIVE:   drive = 1'b1;
            CH_QUALIFY: drive = 1'b1;
            CH_RETRY:   oc_latched = 1'b1;
        endcase
    end

endmodule

// File: rtl/lsd_open_qual.sv
module lsd_open_qual
    import lsd_fsup_pkg::*;
#(
    parameter int OL_CYC = 1250
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd,
    input  logic drive,
    input  logic open_det,
    output logic ol_latched
);

    localparam int OW = cnt_bits(OL_CYC);
    localparam logic [OW-1:0] OL_LAST = OW'(OL_CYC - 1);

    logic [OW-1:0] cnt_q;
    logic          lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lat_q <= 1'b0;
        end else if (cmd) begin
            cnt_q <= '0;
            lat_q <= 1'b0;
        end else if (lat_q) begin
            cnt_q <= '0;
        end else if (!drive && open_det) begin
            if (cnt_q == OL_LAST) begin
                lat_q <= 1'b1;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign ol_latched = lat_q;

endmodule

// File: rtl/lsd_fault_merge.sv
module lsd_fault_merge #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] oc_lat,
    input  logic [NCH-1:0] ol_lat,
    input  logic           ot,
    output logic [NCH-1:0] ch_fault,
    output logic           fault_n
);

    always_comb begin
        ch_fault = oc_lat | ol_lat;
        fault_n  = !((|ch_fault) || ot);
    end

endmodule

// File: rtl/lsd_fault_sup.sv
module lsd_fault_sup #(
    parameter int NCH        = 4,
    parameter int OCP_DG_CYC = 438,
    parameter int RETRY_CYC  = 150000,
    parameter int OL_DG_CYC  = 1250
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] ch_cmd,
    input  logic [NCH-1:0] ch_oc,
    input  logic [NCH-1:0] ch_open,
    input  logic           over_temp,
    input  logic           under_volt,
    output logic [NCH-1:0] ch_drive,
    output logic [NCH-1:0] ch_fault,
    output logic           fault_n
);

    logic           rst_all;
    logic [NCH-1:0] oc_lat;
    logic [NCH-1:0] ol_lat;

    assign rst_all = rst || under_volt;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        lsd_ocp_fsm #(
            .DG_CYC    (OCP_DG_CYC),
            .RETRY_CYC (RETRY_CYC)
        ) u_ocp (
            .clk        (clk),
            .rst        (rst_all),
            .cmd        (ch_cmd[g]),
            .oc         (ch_oc[g]),
            .ot         (over_temp),
            .drive      (ch_drive[g]),
            .oc_latched (oc_lat[g])
        );

        lsd_open_qual #(
            .OL_CYC (OL_DG_CYC)
        ) u_open (
            .clk        (clk),
            .rst        (rst_all),
            .cmd        (ch_cmd[g]),
            .drive      (ch_drive[g]),
            .open_det   (ch_open[g]),
            .ol_latched (ol_lat[g])
        );
    end

    lsd_fault_merge #(
        .NCH (NCH)
    ) u_merge (
        .oc_lat   (oc_lat),
        .ol_lat   (ol_lat),
        .ot       (over_temp),
        .ch_fault (ch_fault),
        .fault_n  (fault_n)
    );

endmodule

// File: rtl/lsd_fsup_chk.sv
module lsd_fsup_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           under_volt,
    input logic           over_temp,
    input logic [NCH-1:0] ch_cmd,
    input logic [NCH-1:0] ch_oc,
    input logic [NCH-1:0] ch_open,
    input logic [NCH-1:0] ch_drive,
    input logic [NCH-1:0] ch_fault,
    input logic           fault_n,
    input logic [NCH-1:0] ol_lat
);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R2
        cmd_off_drive_off_chk: assert property (@(posedge clk) disable iff (rst || under_volt)
            !ch_cmd[i] |=> !ch_drive[i]);

        // R3
        drive_trip_needs_oc_chk: assert property (@(posedge clk) disable iff (rst || under_volt)
            ($fell(ch_drive[i]) && $past(ch_cmd[i]) && !$past(over_temp)
             && !$past(under_volt) && !$past(rst)) |-> $past(ch_oc[i]));

        // R6
        open_set_when_off_chk: assert property (@(posedge clk) disable iff (rst || under_volt)
            $rose(ol_lat[i]) |-> (!$past(ch_cmd[i]) && !$past(ch_drive[i]) && $past(ch_open[i])));

        // R7
        open_cleared_by_cmd_chk: assert property (@(posedge clk) disable iff (rst || under_volt)
            ch_cmd[i] |=> !ol_lat[i]);
    end

    // R8
    ot_pulls_fault_chk: assert property (@(posedge clk) disable iff (rst)
        over_temp |-> !fault_n);

    // R9
    ot_kills_drive_chk: assert property (@(posedge clk) disable iff (rst || under_volt)
        over_temp |=> (ch_drive == '0));

    // R10
    uv_clears_all_chk: assert property (@(posedge clk) disable iff (rst)
        under_volt |=> (ch_drive == '0 && ch_fault == '0));

endmodule

bind lsd_fault_sup lsd_fsup_chk #(.NCH(NCH)) u_fsup_chk (
    .clk        (clk),
    .rst        (rst),
    .under_volt (under_volt),
    .over_temp  (over_temp),
    .ch_cmd     (ch_cmd),
    .ch_oc      (ch_oc),
    .ch_open    (ch_open),
    .ch_drive   (ch_drive),
    .ch_fault   (ch_fault),
    .fault_n    (fault_n),
    .ol_lat     (ol_lat)
);

// File: tb/tb_lsd_fault_sup.sv
`timescale 1ns/1ps
module tb_lsd_fault_sup;

    localparam int NCH = 4;
    localparam int DG  = 5;
    localparam int RT  = 20;
    localparam int OL  = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] ch_cmd = '0;
    logic [NCH-1:0] ch_oc = '0;
    logic [NCH-1:0] ch_open = '0;
    logic           over_temp = 1'b0;
    logic           under_volt = 1'b0;
    logic [NCH-1:0] ch_drive;
    logic [NCH-1:0] ch_fault;
    logic           fault_n;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    lsd_fault_sup #(
        .NCH(NCH), .OCP_DG_CYC(DG), .RETRY_CYC(RT), .OL_DG_CYC(OL)
    ) dut (
        .clk(clk), .rst(rst), .ch_cmd(ch_cmd), .ch_oc(ch_oc), .ch_open(ch_open),
        .over_temp(over_temp), .under_volt(under_volt),
        .ch_drive(ch_drive), .ch_fault(ch_fault), .fault_n(fault_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    // behavioural reference: per-channel run lengths and a retry countdown
    int m_on   [NCH];
    int m_ocrun[NCH];
    int m_left [NCH];
    int m_olrun[NCH];
    int m_ollat[NCH];

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_on[c] = 0; m_ocrun[c] = 0; m_left[c] = 0; m_olrun[c] = 0; m_ollat[c] = 0;
        end
    end

    always @(posedge clk) begin
        logic [NCH-1:0] e_drv, e_flt;
        logic           e_fn;
        for (int c = 0; c < NCH; c++) begin
            if (rst || under_volt) begin
                m_on[c] = 0; m_ocrun[c] = 0; m_left[c] = 0; m_olrun[c] = 0; m_ollat[c] = 0;
            end else begin
                if (ch_cmd[c]) begin
                    m_olrun[c] = 0; m_ollat[c] = 0;
                end else if (m_ollat[c] == 0 && m_on[c] == 0 && ch_open[c]) begin
                    m_olrun[c]++;
                    if (m_olrun[c] == OL) begin m_ollat[c] = 1; m_olrun[c] = 0; end
                end else begin
                    m_olrun[c] = 0;
                end
                if (m_left[c] > 0) begin
                    if (!ch_cmd[c]) m_left[c] = 0;
                    else            m_left[c]--;
                    m_on[c] = 0;
                end else if (m_on[c] != 0) begin
                    if (!ch_cmd[c] || over_temp) begin
                        m_on[c] = 0; m_ocrun[c] = 0;
                    end else if (ch_oc[c]) begin
                        m_ocrun[c]++;
                        if (m_ocrun[c] == DG) begin
                            m_on[c] = 0; m_left[c] = RT; m_ocrun[c] = 0;
                        end
                    end else begin
                        m_ocrun[c] = 0;
                    end
                end else begin
                    m_on[c] = (ch_cmd[c] && !over_temp) ? 1 : 0;
                end
            end
        end
        #2;
        for (int c = 0; c < NCH; c++) begin
            e_drv[c] = (m_on[c] != 0);
            e_flt[c] = (m_left[c] > 0) || (m_ollat[c] != 0);
        end
        e_fn = !((|e_flt) || over_temp);
        if (!finished) begin
            chk("R2 model drive", 32'(ch_drive), 32'(e_drv));
            chk("R8 model fault bits", 32'(ch_fault), 32'(e_flt));
            chk("R8 model fault_n", 32'(fault_n), 32'(e_fn));
        end
    end

    initial begin
        #(8 * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(3);
        // R1 reset state
        chk("R1 drive in reset", 32'(ch_drive), 32'h0);
        chk("R1 fault in reset", 32'(ch_fault), 32'h0);
        chk("R1 fault_n in reset", 32'(fault_n), 32'h1);
        rst = 1'b0;
        step(1);
        chk("R1 drive after reset", 32'(ch_drive), 32'h0);

        // R2 follow command one edge later
        ch_cmd = 4'b0101;
        step(1);
        chk("R2 drive follows 0101", 32'(ch_drive), 32'h5);
        ch_cmd = 4'b1111;
        step(1);
        chk("R2 drive follows 1111", 32'(ch_drive), 32'hF);

        // R7 open ignored while commanded on
        ch_open = 4'b1111;
        step(OL + 4);
        chk("R7 open ignored while on", 32'(ch_fault), 32'h0);
        ch_open = '0;

        // R3 short overcurrent run does not trip
        ch_oc[0] = 1'b1;
        step(DG - 1);
        chk("R3 short run no trip", 32'(ch_drive[0]), 32'h1);
        ch_oc[0] = 1'b0;
        step(1);
        ch_oc[0] = 1'b1;
        step(DG - 1);
        chk("R3 count restarted", 32'(ch_drive[0]), 32'h1);
        step(1);
        chk("R3 trip drive off", 32'(ch_drive[0]), 32'h0);
        chk("R3 trip fault bit", 32'(ch_fault[0]), 32'h1);
        chk("R8 fault_n on trip", 32'(fault_n), 32'h0);
        ch_oc[0] = 1'b0;

        // R4 retry interval
        step(RT - 1);
        chk("R4 still in retry", 32'(ch_fault[0]), 32'h1);
        step(1);
        chk("R4 fault auto clear", 32'(ch_fault[0]), 32'h0);
        chk("R4 drive off at clear", 32'(ch_drive[0]), 32'h0);
        step(1);
        chk("R4 drive resumes", 32'(ch_drive[0]), 32'h1);

        // R5 cleared command ends retry
        ch_oc[1] = 1'b1;
        step(DG);
        chk("R5 ch1 tripped", 32'(ch_fault[1]), 32'h1);
        ch_oc[1] = 1'b0;
        ch_cmd[1] = 1'b0;
        step(1);
        chk("R5 cmd low clears oc", 32'(ch_fault[1]), 32'h0);
        ch_cmd[1] = 1'b1;
        step(1);
        chk("R5 ch1 back on", 32'(ch_drive[1]), 32'h1);

        // R5 reset ends retry
        ch_oc[2] = 1'b1;
        step(DG);
        chk("R5 ch2 tripped", 32'(ch_fault[2]), 32'h1);
        ch_oc[2] = 1'b0;
        rst = 1'b1;
        step(1);
        chk("R5 rst clears oc", 32'(ch_fault[2]), 32'h0);
        rst = 1'b0;
        step(1);
        chk("R5 drive after rst", 32'(ch_drive), 32'hF);

        // R6 open-load qualification
        ch_cmd = '0;
        step(2);
        ch_open[3] = 1'b1;
        step(OL - 1);
        chk("R6 open not yet", 32'(ch_fault[3]), 32'h0);
        step(1);
        chk("R6 open latched", 32'(ch_fault[3]), 32'h1);
        chk("R8 fault_n on open", 32'(fault_n), 32'h0);
        ch_open[2] = 1'b1;
        step(3);
        ch_open[2] = 1'b0;
        step(1);
        ch_open[2] = 1'b1;
        step(OL - 1);
        chk("R6 glitch restarts count", 32'(ch_fault[2]), 32'h0);
        step(1);
        chk("R6 ch2 latched", 32'(ch_fault[2]), 32'h1);

        // R7 command set clears open latch
        ch_cmd[3] = 1'b1;
        step(1);
        chk("R7 cmd clears open", 32'(ch_fault), 32'h4);

        // R9 overtemperature
        ch_cmd = 4'b1111;
        ch_open = '0;
        step(2);
        over_temp = 1'b1;
        step(1);
        chk("R9 ot drive off", 32'(ch_drive), 32'h0);
        chk("R8 ot fault_n", 32'(fault_n), 32'h0);
        over_temp = 1'b0;
        step(1);
        chk("R9 resume after ot", 32'(ch_drive), 32'hF);
        chk("R9 fault_n released", 32'(fault_n), 32'h1);

        // R10 undervoltage
        ch_cmd = '0;
        step(2);
        ch_open = 4'b1111;
        step(OL);
        chk("R10 latches before uv", 32'(ch_fault), 32'hF);
        under_volt = 1'b1;
        step(1);
        chk("R10 uv clears faults", 32'(ch_fault), 32'h0);
        ch_cmd = 4'b1111;
        step(1);
        chk("R10 uv holds drive off", 32'(ch_drive), 32'h0);
        under_volt = 1'b0;
        step(1);
        chk("R10 resume after uv", 32'(ch_drive), 32'hF);
        ch_open = '0;
        step(2);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule